// File: doc/BRIEF.md
# Bit-Serial Adder with Shift-Register Operands

This block adds two unsigned operands of `WIDTH` bits by processing one bit position per clock. Each operand sits in its own right-shifting register. A single full adder combines the two low-order bits with a stored carry on every active cycle. The resulting sum bit enters the top of the augend register, so after `WIDTH` cycles that register holds the sum.

A start pulse loads both operands in parallel, clears the carry and starts an internal bit counter. The counter keeps shifting enabled for exactly `WIDTH` cycles, then drops busy and raises done for one cycle. While the addend register empties, it takes fresh bits on a serial input, so the addend for the next addition can be streamed in during the current one. A later start can keep those streamed bits instead of loading the parallel addend.

Top module: `serial_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its idle state. After that edge, `busy`, `done`, `carry_out` and every bit of `sum` read 0.
- R2: A `start` sampled high while `busy` is low loads `a_in` into the augend register and clears the carry. It also loads `b_in` into the addend register, unless `keep_b` is high. `busy` reads 1 after that edge.
- R3: After an accepted start, `busy` stays high for exactly `WIDTH` cycles and `done` stays low throughout. When `busy` falls, `done` is high for exactly one cycle.
- R4: In the cycle `done` is high, `sum` equals (A + B) mod 2^`WIDTH`, and `carry_out` equals bit `WIDTH` of the full sum A + B, with both operands taken as unsigned.
- R5: Once an addition completes, `sum` and `carry_out` hold their values while the block is idle. They change only on a new accepted start, on `clr_carry` (carry only), or on reset.
- R6: A `start` pulse while `busy` is high is ignored. The running addition keeps its operands, its timing and its result.
- R7: `clr_carry` high at a clock edge makes `carry_out` read 0 after that edge, taking priority over the carry update. `sum` is unaffected.
- R8: During the `WIDTH` shift cycles, the addend register takes `b_ser` in at its most significant end. The bit presented before the first shift therefore ends up as bit 0. A start with `keep_b` high then adds the augend to these streamed bits.
- R9: A `start` presented in the cycle `done` is high is accepted, so additions can run back to back with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_carry | input | 1 | Synchronous clear of the carry flip-flop |
| start | input | 1 | Request a new addition; honoured only when idle |
| keep_b | input | 1 | With start: keep the streamed addend instead of loading `b_in` |
| a_in | input | WIDTH | Parallel augend |
| b_in | input | WIDTH | Parallel addend |
| b_ser | input | 1 | Serial bit shifted into the addend register's top |
| busy | output | 1 | Addition in progress (shift enable) |
| done | output | 1 | One-cycle pulse when the addition finishes |
| sum | output | WIDTH | Augend register contents (the sum after done) |
| carry_out | output | 1 | Carry flip-flop contents (final carry after done) |

## Verification
The bench builds the block with `WIDTH` at its default of 8. At that width, all-ones operands, a lone top-bit carry and fully alternating patterns are reached directly, and random operands cover a useful share of the 65,536 operand pairs. The small width also keeps each addition to eight shift cycles. That leaves room to mix stray start pulses during a running addition, back-to-back starts in the done cycle, and streamed-addend reuse across many random runs.

// File: rtl/serial_adder_pkg.sv
// Shared definitions for the bit-serial adder.
// Assumes: nothing beyond IEEE 1800-2017.
package serial_adder_pkg;

    // Sequencer phases: waiting for a start, or shifting bits.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } add_phase_t;

endpackage

// File: rtl/sa_shift_reg.sv
// Right-shifting register with parallel load.
// Load has priority over shift. The serial output is the LSB.
// Assumes W >= 2.
module sa_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q,
    output logic         ser_out
);

    // Register update: reset, parallel load, or one-bit right shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= par_in;
        else if (shift)
            q <= {ser_in, q[W-1:1]};
    end

    // Low bit is presented to the adder.
    assign ser_out = q[0];

    a_r2_load_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(par_in)));

    a_r8_shift_moves_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && shift) |=> (q[W-1] == $past(ser_in)) && (q[W-2:0] == $past(q[W-1:1])));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(q));

endmodule

// File: rtl/sa_full_adder.sv
// One-bit full adder shared by every bit position.
// Purely combinational.
module sa_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);

    // Sum and majority carry.
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (x & y) | (x & cin) | (y & cin);
    end

endmodule

// File: rtl/sa_sequencer.sv
// Counts N shift cycles after an accepted start, then pulses done.
// A start is accepted only in the idle phase.
// Assumes N >= 2.
module sa_sequencer
    import serial_adder_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic shift_en,
    output logic done
);

    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    add_phase_t    phase;
    logic [CW-1:0] bit_cnt;

    // Start is honoured only while idle.
    assign accept   = start && (phase == PH_IDLE);
    assign shift_en = (phase == PH_RUN);

    // Phase, bit counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_RUN;
                        bit_cnt <= '0;
                    end
                end
                PH_RUN: begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!shift_en && $past(shift_en)));

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (bit_cnt <= LAST));

    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && start && bit_cnt != LAST) |=> (shift_en && bit_cnt == $past(bit_cnt) + 1'b1));

endmodule

// File: rtl/serial_adder.sv
// Bit-serial adder: two right-shifting operand registers, one full adder
// and a carry flip-flop. The sum bit re-enters the augend register, so
// that register holds the sum after WIDTH shift cycles.
// Assumes WIDTH >= 2.
module serial_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_carry,
    input  logic             start,
    input  logic             keep_b,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_ser,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    logic             accept;
    logic             shift_en;
    logic             a_bit;
    logic             b_bit;
    logic             s_bit;
    logic             c_next;
    logic             carry_q;
    logic             load_b;
    logic [WIDTH-1:0] b_q;

    sa_sequencer #(.N(WIDTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (accept),
        .shift_en (shift_en),
        .done     (done)
    );

    // Augend register: its serial input takes the sum bit.
    sa_shift_reg #(.W(WIDTH)) u_reg_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .shift   (shift_en),
        .par_in  (a_in),
        .ser_in  (s_bit),
        .q       (sum),
        .ser_out (a_bit)
    );

    // Addend register: reloads unless the streamed value is kept.
    assign load_b = accept && !keep_b;

    sa_shift_reg #(.W(WIDTH)) u_reg_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_b),
        .shift   (shift_en),
        .par_in  (b_in),
        .ser_in  (b_ser),
        .q       (b_q),
        .ser_out (b_bit)
    );

    sa_full_adder u_fa (
        .x    (a_bit),
        .y    (b_bit),
        .cin  (carry_q),
        .s    (s_bit),
        .cout (c_next)
    );

    // Carry flip-flop: cleared by request or start, else captures carry-out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (clr_carry || accept)
            carry_q <= 1'b0;
        else if (shift_en)
            carry_q <= c_next;
    end

    assign busy      = shift_en;
    assign carry_out = carry_q;

    a_r7_clear_carry: assert property (@(posedge clk) disable iff (!rst_n)
        clr_carry |=> !carry_out);

    a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !carry_out && sum == $past(a_in)));

    a_r5_carry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !clr_carry) |=> $stable(carry_out));

endmodule

// File: tb/serial_adder_test.sv
`timescale 1ns/1ps
module serial_adder_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_carry = 1'b0;
    logic         start = 1'b0;
    logic         keep_b = 1'b0;
    logic [N-1:0] a_in = '0;
    logic [N-1:0] b_in = '0;
    logic         b_ser = 1'b0;
    logic         busy;
    logic         done;
    logic [N-1:0] sum;
    logic         carry_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [N-1:0] streamed = '0;

    always #2.5 clk = ~clk;

    serial_adder #(.WIDTH(N)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_carry (clr_carry),
        .start     (start),
        .keep_b    (keep_b),
        .a_in      (a_in),
        .b_in      (b_in),
        .b_ser     (b_ser),
        .busy      (busy),
        .done      (done),
        .sum       (sum),
        .carry_out (carry_out)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic chk(input string req, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge of the done cycle.
    task automatic run_add(input logic [N-1:0] a, input logic [N-1:0] b,
                           input logic reuse, input logic [N-1:0] nxt,
                           input logic poke, input string tag);
        logic [N-1:0] bop;
        logic [N:0]   exp;
        bop = reuse ? streamed : b;
        exp = ref_add(a, bop);
        start  = 1'b1;
        keep_b = reuse;
        a_in   = a;
        b_in   = b;
        @(negedge clk);
        start  = 1'b0;
        keep_b = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R2 carry cleared", carry_out, 0);
        for (int i = 0; i < N; i++) begin
            b_ser = nxt[i];
            start = poke && (i == 2);        // R6: stray start while busy
            if (poke) begin
                a_in = ~a;
                b_in = ~b;
            end
            chk("R3 busy during shift", busy, 1);
            chk("R3 done low during shift", done, 0);
            @(negedge clk);
        end
        start = 1'b0;
        chk("R3 busy falls after WIDTH", busy, 0);
        chk("R3 done pulse", done, 1);
        chk({tag, " sum"}, sum, exp[N:0] & {1'b0, {N{1'b1}}});
        chk({tag, " carry_out"}, carry_out, exp[N]);
        streamed = nxt;
    endtask

    // One idle cycle: done drops, results hold.
    task automatic idle_after();
        logic [N-1:0] s0;
        logic         c0;
        s0 = sum;
        c0 = carry_out;
        @(negedge clk);
        chk("R3 done single cycle", done, 0);
        chk("R5 sum holds", sum, s0);
        chk("R5 carry holds", carry_out, c0);
    endtask

    task automatic clear_check();
        logic [N-1:0] s0;
        s0 = sum;
        clr_carry = 1'b1;
        @(negedge clk);
        clr_carry = 1'b0;
        chk("R7 carry cleared", carry_out, 0);
        chk("R7 sum untouched", sum, s0);
    endtask

    initial begin
        logic [N-1:0] ra, rb, rn;
        logic         rr, rp, rc;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 sum reset", sum, 0);
        chk("R1 carry reset", carry_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_add(8'h00, 8'h00, 1'b0, 8'h00, 1'b0, "R4 zero");
        idle_after();
        run_add(8'hFF, 8'h01, 1'b0, 8'h00, 1'b0, "R4 full carry chain");
        idle_after();
        clear_check();
        run_add(8'hFF, 8'hFF, 1'b0, 8'h5A, 1'b1, "R6 poked all ones");
        idle_after();
        run_add(8'h80, 8'h80, 1'b0, 8'h3C, 1'b0, "R4 top bit carry");
        run_add(8'h01, 8'h77, 1'b1, 8'hC3, 1'b0, "R9 back to back R8 kept addend");
        idle_after();
        run_add(8'hAA, 8'h55, 1'b0, 8'h00, 1'b0, "R4 alternating");
        idle_after();

        for (int k = 0; k < 60; k++) begin
            ra = N'($urandom);
            rb = N'($urandom);
            rn = N'($urandom);
            rr = 1'($urandom);
            rp = 1'($urandom);
            rc = 1'($urandom);
            run_add(ra, rb, rr, rn, rp, rr ? "R8 random kept" : "R4 random");
            if (!rc) idle_after();
            if (($urandom % 8) == 0) clear_check();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule